// File: doc/BRIEF.md
# Value-Checked Transaction Commit Unit

This block runs one thread's memory transaction and commits it without coherence traffic. The thread sends loads, stores and a final commit request. A load that misses the buffered stores is read from memory, and the address and the value seen go into a private read log. A store stays in a private write log and never reaches memory before commit. A load of an address the thread has already stored to returns the buffered value.

On commit the unit takes the memory lock and re-reads every logged address. It compares each returned value with the value recorded at load time. If all of them match, it writes the buffered stores to memory in the order they were first made, then pulses done. If any value differs, it drops both logs and pulses abort, and the thread must restart the transaction from its beginning. The abort shows only that some other agent changed the data. It does not say which agent did.

Memory is reached through a single-request port. A request is a one-cycle pulse, and one response, for a read or a write, comes back some cycles later. Only one request is outstanding at a time.

Top module: `txCommitUnit`

## Requirements
- R1: An accepted load (opKind 0) whose address is not in the write log issues one memory read of that address. When the response arrives, it raises loadDone for one cycle with the returned data, and it appends the address/value pair to the read log.
- R2: An accepted store (opKind 1) causes no memory write before commit. A store to an address already in the write log replaces that entry's value and takes no new entry.
- R3: On commit (opKind 2), every read-log entry is re-read from memory. If any returned value differs from the logged one, txAbort pulses for one cycle and nothing is written to memory.
- R4: When validation passes, each write-log entry is written to memory once, in the order its address was first stored. commitDone then pulses for one cycle, in the cycle after the last write response.
- R5: A load that hits the write log raises loadDone in the cycle right after acceptance, with the buffered value. It issues no memory request and adds no read-log entry.
- R6: Both logs are empty after commitDone and after txAbort. A commit with both logs empty gives commitDone and makes no memory request.
- R7: A load miss while the read log holds RD_DEPTH entries aborts the transaction. So does a store to a new address while the write log holds WR_DEPTH entries.
- R8: memLock is high from the first validation request to the last write response. Every memory request during commit and every memory write is made with memLock high.
- R9: commitDone and txAbort are never high together. opReady is low whenever memLock is high, and loadDone never rises while memLock is high.
- R10: After reset, opReady is high, and memReqValid, memLock, loadDone, commitDone and txAbort are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Thread operation present |
| opKind | input | 2 | 0 load, 1 store, 2 commit |
| opAddr | input | ADDR_W | Load/store address |
| opData | input | DATA_W | Store value |
| opReady | output | 1 | Unit idle; operation accepted when opValid is high |
| loadDone | output | 1 | Load result pulse |
| loadData | output | DATA_W | Load result value |
| commitDone | output | 1 | Transaction committed pulse |
| txAbort | output | 1 | Conflict or overflow, restart pulse |
| memReqValid | output | 1 | One-cycle memory request |
| memReqWrite | output | 1 | Request is a write |
| memReqAddr | output | ADDR_W | Request address |
| memReqData | output | DATA_W | Write value |
| memRspValid | input | 1 | Response to the outstanding request |
| memRspData | input | DATA_W | Read value |
| memLock | output | 1 | Exclusive memory hold for validation and write-back |

## Verification
The assertions take it for granted that memRspValid comes only for an outstanding request, and only once per request. They also assume the memory honours memLock, so that nothing else changes memory while it is held. The bench memory model answers every request exactly one cycle later. Changes made by the competing thread are applied only between operations, while the unit is idle, and so never inside a locked commit.

// File: rtl/txCommitPkg.sv
package txCommitPkg;
  typedef enum logic [1:0] {OP_LOAD = 2'd0, OP_STORE = 2'd1, OP_COMMIT = 2'd2} opKind_t;
  typedef enum logic [1:0] {SRC_LOAD, SRC_CHECK, SRC_FLUSH} memSrc_t;
  typedef struct packed {
    logic    latchOp;
    logic    rdAppend;
    logic    wrPut;
    logic    loadFromLog;
    logic    loadFromMem;
    logic    idxClear;
    logic    idxInc;
    logic    commitOk;
    logic    abortTx;
    memSrc_t memSrc;
  } strobes_t;
endpackage

// File: rtl/txCommitPath.sv
module txCommitPath
  import txCommitPkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 16,
  parameter int RD_DEPTH = 4,
  parameter int WR_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          stb,
  input  logic [ADDR_W-1:0] opAddr,
  input  logic [DATA_W-1:0] opData,
  input  logic [DATA_W-1:0] memRspData,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic [DATA_W-1:0] memReqData,
  output logic              wrHit,
  output logic              rdFull,
  output logic              wrFull,
  output logic              rdEmpty,
  output logic              wrEmpty,
  output logic              rdLast,
  output logic              wrLast,
  output logic              checkMatch,
  output logic              loadDone,
  output logic [DATA_W-1:0] loadData,
  output logic              commitDone,
  output logic              txAbort
);
  localparam int MAX_DEPTH = (RD_DEPTH > WR_DEPTH) ? RD_DEPTH : WR_DEPTH;
  localparam int CNT_W = $clog2(MAX_DEPTH + 1);
  localparam int RD_IW = $clog2(RD_DEPTH);
  localparam int WR_IW = $clog2(WR_DEPTH);

  logic [ADDR_W-1:0] rdAddrQ [RD_DEPTH];
  logic [DATA_W-1:0] rdDataQ [RD_DEPTH];
  logic [ADDR_W-1:0] wrAddrQ [WR_DEPTH];
  logic [DATA_W-1:0] wrDataQ [WR_DEPTH];
  logic [CNT_W-1:0]  rdCount, wrCount, idx;
  logic [ADDR_W-1:0] curAddr;
  logic [WR_DEPTH-1:0] hitVec;
  logic [WR_IW-1:0]  hitIdx;
  logic [RD_IW-1:0]  rdIdx;
  logic [WR_IW-1:0]  wrIdx;
  logic              clearLogs;

  assign clearLogs = stb.commitOk | stb.abortTx;
  assign rdIdx = idx[RD_IW-1:0];
  assign wrIdx = idx[WR_IW-1:0];

  // one address comparator per write-log entry
  for (genvar g = 0; g < WR_DEPTH; g++) begin : gMatch
    assign hitVec[g] = (CNT_W'(g) < wrCount) && (wrAddrQ[g] == opAddr);
  end
  assign wrHit = |hitVec;

  always_comb begin
    hitIdx = '0;
    for (int i = 0; i < WR_DEPTH; i++)
      if (hitVec[i]) hitIdx = WR_IW'(i);
  end

  assign rdFull     = (rdCount == CNT_W'(RD_DEPTH));
  assign wrFull     = (wrCount == CNT_W'(WR_DEPTH));
  assign rdEmpty    = (rdCount == '0);
  assign wrEmpty    = (wrCount == '0);
  assign rdLast     = ((idx + CNT_W'(1)) == rdCount);
  assign wrLast     = ((idx + CNT_W'(1)) == wrCount);
  assign checkMatch = (memRspData == rdDataQ[rdIdx]);

  always_comb begin
    memReqData = wrDataQ[wrIdx];
    unique case (stb.memSrc)
      SRC_CHECK: memReqAddr = rdAddrQ[rdIdx];
      SRC_FLUSH: memReqAddr = wrAddrQ[wrIdx];
      default:   memReqAddr = curAddr;
    endcase
  end

  // log storage
  always_ff @(posedge clk) begin
    for (int i = 0; i < RD_DEPTH; i++)
      if (stb.rdAppend && rdCount == CNT_W'(i)) begin
        rdAddrQ[i] <= curAddr;
        rdDataQ[i] <= memRspData;
      end
    for (int i = 0; i < WR_DEPTH; i++)
      if (stb.wrPut && ((wrHit && hitIdx == WR_IW'(i)) || (!wrHit && wrCount == CNT_W'(i)))) begin
        wrAddrQ[i] <= opAddr;
        wrDataQ[i] <= opData;
      end
    if (stb.latchOp) curAddr <= opAddr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdCount    <= '0;
      wrCount    <= '0;
      idx        <= '0;
      loadDone   <= 1'b0;
      loadData   <= '0;
      commitDone <= 1'b0;
      txAbort    <= 1'b0;
    end else begin
      if (clearLogs) begin
        rdCount <= '0;
        wrCount <= '0;
      end else begin
        if (stb.rdAppend) rdCount <= rdCount + CNT_W'(1);
        if (stb.wrPut && !wrHit) wrCount <= wrCount + CNT_W'(1);
      end
      if (stb.idxClear)    idx <= '0;
      else if (stb.idxInc) idx <= idx + CNT_W'(1);
      loadDone   <= stb.loadFromLog | stb.loadFromMem;
      if (stb.loadFromLog)      loadData <= wrDataQ[hitIdx];
      else if (stb.loadFromMem) loadData <= memRspData;
      commitDone <= stb.commitOk;
      txAbort    <= stb.abortTx;
    end
  end
endmodule

// File: rtl/txCommitCtrl.sv
module txCommitCtrl
  import txCommitPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       opValid,
  input  logic [1:0] opKind,
  input  logic       memRspValid,
  input  logic       wrHit,
  input  logic       rdFull,
  input  logic       wrFull,
  input  logic       rdEmpty,
  input  logic       wrEmpty,
  input  logic       rdLast,
  input  logic       wrLast,
  input  logic       checkMatch,
  output strobes_t   stb,
  output logic       opReady,
  output logic       memReqValid,
  output logic       memReqWrite,
  output logic       memLock
);
  typedef enum logic [2:0] {
    S_IDLE, S_LD_REQ, S_LD_WAIT, S_CHK_REQ, S_CHK_WAIT, S_WB_REQ, S_WB_WAIT
  } state_t;

  state_t state, nextState;

  assign opReady = (state == S_IDLE);
  assign memLock = (state == S_CHK_REQ) || (state == S_CHK_WAIT) ||
                   (state == S_WB_REQ)  || (state == S_WB_WAIT);

  always_comb begin
    stb         = '0;
    stb.memSrc  = SRC_LOAD;
    nextState   = state;
    memReqValid = 1'b0;
    memReqWrite = 1'b0;
    unique case (state)
      S_IDLE: if (opValid) begin
        if (opKind == OP_LOAD) begin
          if (wrHit)       stb.loadFromLog = 1'b1;
          else if (rdFull) stb.abortTx = 1'b1;
          else begin
            stb.latchOp = 1'b1;
            nextState   = S_LD_REQ;
          end
        end else if (opKind == OP_STORE) begin
          if (wrHit || !wrFull) stb.wrPut = 1'b1;
          else                  stb.abortTx = 1'b1;
        end else if (opKind == OP_COMMIT) begin
          stb.idxClear = 1'b1;
          if (!rdEmpty)      nextState = S_CHK_REQ;
          else if (!wrEmpty) nextState = S_WB_REQ;
          else               stb.commitOk = 1'b1;
        end
      end
      S_LD_REQ: begin
        memReqValid = 1'b1;
        nextState   = S_LD_WAIT;
      end
      S_LD_WAIT: if (memRspValid) begin
        stb.rdAppend    = 1'b1;
        stb.loadFromMem = 1'b1;
        nextState       = S_IDLE;
      end
      S_CHK_REQ: begin
        stb.memSrc  = SRC_CHECK;
        memReqValid = 1'b1;
        nextState   = S_CHK_WAIT;
      end
      S_CHK_WAIT: begin
        stb.memSrc = SRC_CHECK;
        if (memRspValid) begin
          if (!checkMatch) begin
            stb.abortTx = 1'b1;
            nextState   = S_IDLE;
          end else if (rdLast) begin
            stb.idxClear = 1'b1;
            if (!wrEmpty) nextState = S_WB_REQ;
            else begin
              stb.commitOk = 1'b1;
              nextState    = S_IDLE;
            end
          end else begin
            stb.idxInc = 1'b1;
            nextState  = S_CHK_REQ;
          end
        end
      end
      S_WB_REQ: begin
        stb.memSrc  = SRC_FLUSH;
        memReqValid = 1'b1;
        memReqWrite = 1'b1;
        nextState   = S_WB_WAIT;
      end
      S_WB_WAIT: begin
        stb.memSrc = SRC_FLUSH;
        if (memRspValid) begin
          if (wrLast) begin
            stb.commitOk = 1'b1;
            nextState    = S_IDLE;
          end else begin
            stb.idxInc = 1'b1;
            nextState  = S_WB_REQ;
          end
        end
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end
endmodule

// File: rtl/txCommitUnit.sv
module txCommitUnit
  import txCommitPkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 16,
  parameter int RD_DEPTH = 4,
  parameter int WR_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [1:0]        opKind,
  input  logic [ADDR_W-1:0] opAddr,
  input  logic [DATA_W-1:0] opData,
  output logic              opReady,
  output logic              loadDone,
  output logic [DATA_W-1:0] loadData,
  output logic              commitDone,
  output logic              txAbort,
  output logic              memReqValid,
  output logic              memReqWrite,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic [DATA_W-1:0] memReqData,
  input  logic              memRspValid,
  input  logic [DATA_W-1:0] memRspData,
  output logic              memLock
);
  strobes_t stb;
  logic wrHit, rdFull, wrFull, rdEmpty, wrEmpty, rdLast, wrLast, checkMatch;

  txCommitCtrl i_ctrl (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opKind(opKind),
    .memRspValid(memRspValid), .wrHit(wrHit), .rdFull(rdFull), .wrFull(wrFull),
    .rdEmpty(rdEmpty), .wrEmpty(wrEmpty), .rdLast(rdLast), .wrLast(wrLast),
    .checkMatch(checkMatch), .stb(stb), .opReady(opReady),
    .memReqValid(memReqValid), .memReqWrite(memReqWrite), .memLock(memLock)
  );

  txCommitPath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RD_DEPTH(RD_DEPTH), .WR_DEPTH(WR_DEPTH)
  ) i_path (
    .clk(clk), .rstN(rstN), .stb(stb), .opAddr(opAddr), .opData(opData),
    .memRspData(memRspData), .memReqAddr(memReqAddr), .memReqData(memReqData),
    .wrHit(wrHit), .rdFull(rdFull), .wrFull(wrFull), .rdEmpty(rdEmpty),
    .wrEmpty(wrEmpty), .rdLast(rdLast), .wrLast(wrLast), .checkMatch(checkMatch),
    .loadDone(loadDone), .loadData(loadData), .commitDone(commitDone),
    .txAbort(txAbort)
  );
endmodule

// File: rtl/txCommitChecker.sv
module txCommitChecker (
  input logic clk,
  input logic rstN,
  input logic opReady,
  input logic memReqValid,
  input logic memReqWrite,
  input logic memLock,
  input logic loadDone,
  input logic commitDone,
  input logic txAbort
);
  assert_write_locked_R8: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && memReqWrite) |-> memLock);

  assert_one_outcome_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(commitDone && txAbort));

  assert_busy_blocks_ops_R9: assert property (@(posedge clk) disable iff (!rstN)
    memLock |-> (!opReady && !loadDone));

  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    commitDone |=> !commitDone);

  assert_abort_pulse_R3: assert property (@(posedge clk) disable iff (!rstN)
    txAbort |=> !txAbort);

  assert_single_request_R1: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |=> !memReqValid);

  assert_lock_drop_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(memLock) |-> (commitDone || txAbort));
endmodule

bind txCommitUnit txCommitChecker i_txCommitChecker (
  .clk(clk), .rstN(rstN), .opReady(opReady), .memReqValid(memReqValid),
  .memReqWrite(memReqWrite), .memLock(memLock), .loadDone(loadDone),
  .commitDone(commitDone), .txAbort(txAbort)
);

// File: tb/test_txCommitUnit.sv
module test_txCommitUnit;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int DEPTH = 4;
  localparam int EV_NONE = 0, EV_LOAD = 1, EV_DONE = 2, EV_ABORT = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic opValid = 1'b0;
  logic [1:0] opKind = 2'd0;
  logic [AW-1:0] opAddr = '0;
  logic [DW-1:0] opData = '0;
  logic opReady, loadDone, commitDone, txAbort, memReqValid, memReqWrite, memLock;
  logic [DW-1:0] loadData, memReqData;
  logic [AW-1:0] memReqAddr;
  logic memRspValid;
  logic [DW-1:0] memRspData;

  always #2 clk = ~clk;

  txCommitUnit #(.ADDR_W(AW), .DATA_W(DW), .RD_DEPTH(DEPTH), .WR_DEPTH(DEPTH)) i_txCommitUnit (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opKind(opKind), .opAddr(opAddr),
    .opData(opData), .opReady(opReady), .loadDone(loadDone), .loadData(loadData),
    .commitDone(commitDone), .txAbort(txAbort), .memReqValid(memReqValid),
    .memReqWrite(memReqWrite), .memReqAddr(memReqAddr), .memReqData(memReqData),
    .memRspValid(memRspValid), .memRspData(memRspData), .memLock(memLock)
  );

  int checks = 0;
  int fails = 0;

  // bench memory, one-cycle response, pokes model the competing thread
  logic [DW-1:0] memArr [16];
  int  reqCount = 0;
  int  lockErr = 0;
  int  wrSeen [$];
  logic pokeEn = 1'b0;
  logic [AW-1:0] pokeAddr = '0;
  logic [DW-1:0] pokeData = '0;
  logic inCommit = 1'b0;

  always @(posedge clk) begin
    memRspValid <= 1'b0;
    if (!rstN) begin
      for (int i = 0; i < 16; i++) memArr[i] <= DW'(i);
    end else begin
      if (pokeEn) memArr[pokeAddr] <= pokeData;
      if (memReqValid) begin
        reqCount++;
        memRspValid <= 1'b1;
        memRspData  <= memArr[memReqAddr];
        if (memReqWrite) begin
          memArr[memReqAddr] <= memReqData;
          wrSeen.push_back(int'(memReqAddr));
          if (!memLock) lockErr++;
        end
        if (inCommit && !memLock) lockErr++;
      end
    end
  end

  // behavioural reference
  int modelMem [16];
  int rdA [$], rdV [$], wrA [$], wrV [$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic poke(input int a, input int d);
    @(negedge clk);
    pokeEn = 1'b1; pokeAddr = AW'(a); pokeData = DW'(d);
    @(negedge clk);
    pokeEn = 1'b0;
    modelMem[a] = d;
  endtask

  task automatic memCompare(input string tag);
    int bad = 0;
    for (int i = 0; i < 16; i++) if (int'(memArr[i]) != modelMem[i]) bad++;
    chk(bad == 0, tag, bad, 0);
  endtask

  task automatic runOp(input int k, input int a, input int d, input string tag);
    int expEv = EV_NONE, expVal = 0, gotEv = EV_NONE, gotVal = 0, lat = 0;
    bit hit = 0, ok;
    int reqBefore;
    int expOrder [$];
    for (int i = 0; i < wrA.size(); i++) if (wrA[i] == a) begin hit = 1; expVal = wrV[i]; end
    if (k == 0) begin
      if (hit) expEv = EV_LOAD;
      else if (rdA.size() == DEPTH) expEv = EV_ABORT;
      else begin
        expEv = EV_LOAD; expVal = modelMem[a];
        rdA.push_back(a); rdV.push_back(modelMem[a]);
      end
    end else if (k == 1) begin
      if (hit) begin
        for (int i = 0; i < wrA.size(); i++) if (wrA[i] == a) wrV[i] = d;
      end else if (wrA.size() == DEPTH) expEv = EV_ABORT;
      else begin wrA.push_back(a); wrV.push_back(d); end
    end else begin
      ok = 1;
      for (int i = 0; i < rdA.size(); i++) if (modelMem[rdA[i]] != rdV[i]) ok = 0;
      expEv = ok ? EV_DONE : EV_ABORT;
      if (ok) for (int i = 0; i < wrA.size(); i++) begin
        modelMem[wrA[i]] = wrV[i];
        expOrder.push_back(wrA[i]);
      end
    end
    if (expEv == EV_ABORT || expEv == EV_DONE) begin
      rdA.delete(); rdV.delete(); wrA.delete(); wrV.delete();
    end
    while (!opReady) @(negedge clk);
    wrSeen.delete();
    reqBefore = reqCount;
    @(negedge clk);
    opValid = 1'b1; opKind = 2'(k); opAddr = AW'(a); opData = DW'(d);
    inCommit = (k == 2);
    @(negedge clk);
    opValid = 1'b0;
    for (int c = 0; c < 30 && gotEv == EV_NONE; c++) begin
      if (c > 0) @(negedge clk);
      lat = c;
      if (loadDone) begin gotEv = EV_LOAD; gotVal = int'(loadData); end
      else if (commitDone) gotEv = EV_DONE;
      else if (txAbort) gotEv = EV_ABORT;
    end
    inCommit = 1'b0;
    chk(gotEv == expEv, {tag, " outcome"}, gotEv, expEv);
    if (expEv == EV_LOAD) chk(gotVal == expVal, {tag, " load value"}, gotVal, expVal);
    if (k == 0 && hit) begin
      chk(lat == 0, {tag, " R5 hit latency"}, lat, 0);
      chk(reqCount == reqBefore, {tag, " R5 no memory request"}, reqCount - reqBefore, 0);
    end
    if (k == 2 && expEv == EV_DONE) begin
      chk(wrSeen.size() == expOrder.size(), {tag, " R4 write count"}, wrSeen.size(), expOrder.size());
      for (int i = 0; i < expOrder.size() && i < wrSeen.size(); i++)
        chk(wrSeen[i] == expOrder[i], {tag, " R4 write order"}, wrSeen[i], expOrder[i]);
    end
    if (k == 2 && expEv == EV_ABORT)
      chk(wrSeen.size() == 0, {tag, " R3 no write on abort"}, wrSeen.size(), 0);
    @(negedge clk);
    memCompare({tag, " memory image"});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) modelMem[i] = i;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R10 reset state
    chk(opReady == 1'b1, "R10 opReady", opReady, 1);
    chk({memReqValid, memLock, loadDone, commitDone, txAbort} == 5'b0, "R10 idle outputs",
        {memReqValid, memLock, loadDone, commitDone, txAbort}, 0);

    // first transaction B=A+1 with A at 1, B at 2
    runOp(0, 1, 0, "R1 load A miss");
    runOp(1, 2, 2, "R2 store B buffered");
    runOp(0, 2, 0, "R5 load B from write log");
    poke(1, 4); // competing thread commits A=B+2
    runOp(2, 0, 0, "R3 conflicting commit");
    // retry: logs must be empty, so B is read from memory again
    runOp(0, 2, 0, "R6 load B after abort");
    runOp(0, 1, 0, "R1 load A retry");
    runOp(1, 2, 5, "R2 store B retry");
    runOp(2, 0, 0, "R4 retry commit");
    // second transaction A=B+2, no interference
    runOp(0, 2, 0, "R1 load B");
    runOp(1, 1, 7, "R2 store A");
    runOp(2, 0, 0, "R4 second commit");
    // write order with an overwrite
    runOp(1, 3, 30, "R2 store 3");
    runOp(1, 5, 50, "R2 store 5");
    runOp(1, 4, 40, "R2 store 4");
    runOp(1, 3, 33, "R2 overwrite 3");
    runOp(0, 3, 0, "R5 load overwritten value");
    runOp(2, 0, 0, "R4 ordered write-back");
    // read log overflow
    for (int i = 6; i < 10; i++) runOp(0, i, 0, "R1 fill read log");
    runOp(0, 10, 0, "R7 read log overflow");
    runOp(2, 0, 0, "R6 empty commit");
    // write log overflow
    for (int i = 6; i < 10; i++) runOp(1, i, 100 + i, "R2 fill write log");
    runOp(1, 11, 99, "R7 write log overflow");
    runOp(2, 0, 0, "R6 commit after overflow");
    // full write log accepts a repeat address
    for (int i = 6; i < 10; i++) runOp(1, i, 120 + i, "R2 fill write log again");
    runOp(1, 6, 77, "R7 full log repeat address");
    runOp(2, 0, 0, "R4 commit full write log");

    chk(lockErr == 0, "R8 requests under lock", lockErr, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule